// File: doc/BRIEF.md
# Timer Count-Clock Selector

This block decides when an 8-bit timer/event counter advances. Each cycle in which the counter should step, it raises `cnt_en` for exactly one system clock. The step source is one of six taps on a free-running prescaler of the system clock, or one chosen edge of an external event line. Software picks the source through a 3-bit field held in an 8-bit control register, which can be written and read back.

The external event line goes through a two-flop synchroniser. An edge tracker then follows it with two named states. `SEEN_LOW` is the reset state. It moves to `SEEN_HIGH` when the synchronised line is 1, and a rising pulse fires during that transition. `SEEN_HIGH` returns to `SEEN_LOW` when the synchronised line is 0, and a falling pulse fires during that transition. In every other cycle the tracker stays in its state.

When the channel is the second half of a cascaded pair, `cascade_en` is high. The channel then takes its strobe from the first channel's `link_tick` and ignores its own select field. While `run` is low, no strobes are produced, but the prescaler keeps counting. Because of this, the first tick after a start can arrive before a full period has passed.

Top module: `tmr_clksel`

## Requirements
- R1: After reset the control register holds 00H, and `cfg_rdata` reads 8'h00.
- R2: A write stores only `cfg_wdata[2:0]`. Bits 7..3 of `cfg_rdata` always read 0, so a write of 8'hFF reads back as 8'h07.
- R3: Select codes 3'b010, 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 divide the system clock by 4, 8, 16, 32, 128 and 512. Over any 1024 consecutive running cycles this gives 256, 128, 64, 32, 8 and 2 strobes.
- R4: Select code 3'b000 gives exactly one single-cycle strobe for each falling edge of `evt_in`, and none for rising edges.
- R5: Select code 3'b001 gives exactly one single-cycle strobe for each rising edge of `evt_in`, and none for falling edges.
- R6: A write made while `run` is 1 is ignored. The read-back value stays the same.
- R7: While `run` is 0, `cnt_en` stays 0 whatever the select code is.
- R8: While `cascade_en` is 1, `cnt_en` follows `link_tick` (gated by `run`), and the select field has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer running flag; gates strobes and blocks writes |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| evt_in | input | 1 | Asynchronous external event line |
| cascade_en | input | 1 | Channel is the second half of a cascaded pair |
| link_tick | input | 1 | Strobe from the first channel of the pair |
| cnt_en | output | 1 | Single-cycle count-enable strobe |

## Verification
A wrong prescaler value or a wrong tap decode changes the number of strobes in a 1024-cycle window. It shows within one window, even for the slowest tap. If the edge tracker sits in the wrong state, it either misses an edge or fires a spurious strobe. This appears as a wrong count within a few cycles of the next transition on `evt_in`. A select field that was corrupted or overwritten while running shows at once on `cfg_rdata`. It also shows as a strobe rate that does not match the field.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [2:0] {
        SEL_FALL = 3'd0,
        SEL_RISE = 3'd1,
        SEL_D4   = 3'd2,
        SEL_D8   = 3'd3,
        SEL_D16  = 3'd4,
        SEL_D32  = 3'd5,
        SEL_D128 = 3'd6,
        SEL_D512 = 3'd7
    } sel_e;

    typedef enum logic {
        SEEN_LOW  = 1'b0,
        SEEN_HIGH = 1'b1
    } edge_st_e;

    localparam int NUM_TAPS = 6;

    // log2 of the divide ratio for each tap index
    function automatic int tap_log2(input int idx);
        case (idx)
            0: return 2;
            1: return 3;
            2: return 4;
            3: return 5;
            4: return 7;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int PRE_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [tcs_pkg::NUM_TAPS-1:0]  tick
);
    import tcs_pkg::*;

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int LW = tap_log2(g);
        assign tick[g] = (pre_cnt[LW-1:0] == '0);
    end

    // R3: the fastest tap never fires in two adjacent cycles
    p_tap4_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick[0] |=> !tick[0]);
    // R3: the slowest tap only fires together with every faster tap
    p_tap512_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick[NUM_TAPS-1] |-> (&tick));
endmodule

// File: rtl/tcs_edge_fsm.sv
module tcs_edge_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic rise_p,
    output logic fall_p
);
    import tcs_pkg::*;

    logic     sync1, sync2;
    edge_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= evt_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEEN_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        rise_p = 1'b0;
        fall_p = 1'b0;
        unique case (st_q)
            SEEN_LOW: if (sync2) begin
                st_d   = SEEN_HIGH;
                rise_p = 1'b1;
            end
            SEEN_HIGH: if (!sync2) begin
                st_d   = SEEN_LOW;
                fall_p = 1'b1;
            end
            default: st_d = SEEN_LOW;
        endcase
    end

    // R5: each rising edge yields a single-cycle pulse
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> !rise_p);
    // R4: each falling edge yields a single-cycle pulse
    p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> !fall_p);
endmodule

// File: rtl/tcs_ctrl_reg.sv
module tcs_ctrl_reg #(
    parameter int REG_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [SEL_W-1:0] sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sel <= '0;
        else if (we && !run) sel <= wdata[SEL_W-1:0];
    end

    assign rdata = {{(REG_W-SEL_W){1'b0}}, sel};

    // R6: the field holds still across any cycle in which the timer runs
    p_hold_while_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(sel));
    // R2: the upper read-back bits stay zero
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-1:SEL_W] == '0);
endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
    parameter int REG_W = 8,
    parameter int SEL_W = 3,
    parameter int PRE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             evt_in,
    input  logic             cascade_en,
    input  logic             link_tick,
    output logic             cnt_en
);
    import tcs_pkg::*;

    logic [SEL_W-1:0]    sel_raw;
    logic [NUM_TAPS-1:0] tick;
    logic                rise_p, fall_p;
    logic                own_en;
    sel_e                sel;

    tcs_ctrl_reg #(.REG_W(REG_W), .SEL_W(SEL_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .run(run), .we(cfg_we),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .sel(sel_raw)
    );

    tcs_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tcs_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .rise_p(rise_p), .fall_p(fall_p)
    );

    assign sel = sel_e'(sel_raw);

    always_comb begin
        own_en = 1'b0;
        unique case (sel)
            SEL_FALL: own_en = fall_p;
            SEL_RISE: own_en = rise_p;
            SEL_D4:   own_en = tick[0];
            SEL_D8:   own_en = tick[1];
            SEL_D16:  own_en = tick[2];
            SEL_D32:  own_en = tick[3];
            SEL_D128: own_en = tick[4];
            SEL_D512: own_en = tick[5];
            default:  own_en = 1'b0;
        endcase
    end

    assign cnt_en = run && (cascade_en ? link_tick : own_en);

    // R7: a stopped timer sees no strobes
    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cnt_en);
    // R8: in cascade mode, a strobe needs the link pulse
    p_cascade_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && !link_tick) |-> !cnt_en);
endmodule

// File: tb/tb_tmr_clksel.sv
module tb_tmr_clksel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       evt_in = 1'b0;
    logic       cascade_en = 1'b0;
    logic       link_tick = 1'b0;
    logic       cnt_en;

    int n_tests = 0;
    int n_fail  = 0;
    int pcount  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tmr_clksel dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_in(evt_in),
        .cascade_en(cascade_en), .link_tick(link_tick), .cnt_en(cnt_en)
    );

    always @(negedge clk) if (cnt_en) pcount++;

    // columns: select code, expected strobes over 1024 cycles
    localparam int NV = 6;
    localparam int VEC [NV][2] = '{
        '{2, 256}, '{3, 128}, '{4, 64}, '{5, 32}, '{6, 8}, '{7, 2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic evt_set(input logic v);
        evt_in = v;
        repeat (6) step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset readback", cfg_rdata, 8'h00);

        // R3 vector walk
        for (int i = 0; i < NV; i++) begin
            run = 1'b0;
            wr(VEC[i][0][7:0]);
            check("R2 readback of code", cfg_rdata, VEC[i][0]);
            run = 1'b1;
            pcount = 0;
            repeat (1024) step();
            check("R3 strobes per 1024", pcount, VEC[i][1]);
        end

        // R2 upper bits
        run = 1'b0;
        wr(8'hFF);
        check("R2 upper bits zero", cfg_rdata, 8'h07);

        // R6 write while running ignored
        wr(8'h02);
        run = 1'b1;
        wr(8'h05);
        check("R6 running write ignored", cfg_rdata, 8'h02);

        // R7 stopped gives no strobes
        run = 1'b0;
        pcount = 0;
        repeat (100) step();
        check("R7 stopped strobes", pcount, 0);

        // R4 falling edges
        wr(8'h00);
        run = 1'b1;
        repeat (4) step();
        pcount = 0;
        for (int k = 0; k < 3; k++) begin
            evt_set(1'b1);
            evt_set(1'b0);
        end
        check("R4 falling strobes", pcount, 3);
        pcount = 0;
        evt_set(1'b1);
        check("R4 rising edge ignored", pcount, 0);

        // R5 rising edges
        run = 1'b0;
        evt_set(1'b0);
        wr(8'h01);
        run = 1'b1;
        pcount = 0;
        for (int k = 0; k < 4; k++) begin
            evt_set(1'b1);
            evt_set(1'b0);
        end
        check("R5 rising strobes", pcount, 4);

        // R8 cascade
        run = 1'b0;
        wr(8'h02);
        cascade_en = 1'b1;
        run = 1'b1;
        pcount = 0;
        for (int k = 0; k < 3; k++) begin
            link_tick = 1'b1; step();
            link_tick = 1'b0; repeat (9) step();
        end
        check("R8 cascade follows link", pcount, 3);
        pcount = 0;
        repeat (40) step();
        check("R8 own select ignored", pcount, 0);
        run = 1'b0;
        pcount = 0;
        link_tick = 1'b1; repeat (3) step(); link_tick = 1'b0;
        check("R7 cascade stopped", pcount, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule